// File: doc/BRIEF.md
# Operand Address Generator for Register/Memory Byte Forms

This block turns the addressing bytes of a 32-bit instruction into an operand location. It takes the addressing-form byte, the optional scaled-index byte, a raw displacement word and the current contents of the eight general registers. From these it produces one of two answers. The operand is either a register, given by its number, or it is in memory, given by its effective address.

It also reports two lengths: whether the scaled-index byte is consumed, and how many displacement bytes (0, 1 or 4) the instruction carries. A fetch stage uses these to step past the operand bytes. The 3-bit register/sub-operation field of the form byte is passed through unchanged for the opcode decoder. Results are captured in one register stage on a clock edge where the request strobe is high.

Top module: `ea_gen`

## Requirements
- R1: With form byte bits [7:6] (mode) equal to 3, the result is a register operand. is_reg_o is 1, reg_idx_o equals form bits [2:0] (rm), ea_o is 0, sib_used_o is 0 and disp_len_o is 0.
- R2: With mode 0 and rm not 4 or 5, ea_o equals the register numbered rm, with disp_len_o 0. Register k occupies regs_i[32k+31:32k].
- R3: With mode 1, disp_i[7:0] is sign-extended and added to the address. Bits disp_i[31:8] are ignored, and disp_len_o is 1.
- R4: With mode 2, the full disp_i word is added to the address, and disp_len_o is 4.
- R5: With mode 0 and rm 5, no register is used and ea_o equals disp_i, with disp_len_o 4.
- R6: With rm 4 and mode not 3, sib_used_o is 1. The address is base + (index << scale) + displacement, where the index byte carries scale in bits [7:6], index in [5:3] and base in [2:0]. Scale codes 0 to 3 multiply by 1, 2, 4 and 8.
- R7: An index field of 4 removes the index term whatever the scale. A base field of 4 selects register 4.
- R8: With mode 0 and base field 5, the base term is absent and a 4-byte displacement is added. With mode 1 or 2, base field 5 selects register 5.
- R9: All address sums wrap modulo 2^32.
- R10: Outputs update on the first rising clock edge with valid_i high, and valid_o is high in the following cycle. When valid_i is low, valid_o is low and all other outputs hold.
- R11: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; inputs are captured on this cycle's edge |
| modrm_i | input | 8 | Addressing-form byte: mode [7:6], reg field [5:3], rm [2:0] |
| sib_i | input | 8 | Scaled-index byte: scale [7:6], index [5:3], base [2:0] |
| disp_i | input | 32 | Raw displacement; low byte only for 1-byte forms |
| regs_i | input | 256 | Eight register values, register k at bits [32k+31:32k] |
| valid_o | output | 1 | Result captured on the last edge |
| is_reg_o | output | 1 | Operand is a register |
| reg_idx_o | output | 3 | Register number when is_reg_o is 1, else 0 |
| reg_field_o | output | 3 | Pass-through of the form byte's reg/sub-operation field |
| ea_o | output | 32 | Effective address when is_reg_o is 0, else 0 |
| sib_used_o | output | 1 | Scaled-index byte consumed |
| disp_len_o | output | 3 | Displacement bytes consumed: 0, 1 or 4 |

## Verification
The properties assume that the form byte, index byte and displacement are stable around the edge where valid_i is high. They also assume valid_i is held low for the whole of reset, so that the one-cycle relation between request and result is never judged across reset release. The bench drives every input on the falling edge, keeps valid_i low until reset has been released, and raises it for single cycles only. Each addressing form is reached through a separate directed scenario, and register values are chosen distinct so that a wrong register selection shows up in the address.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;
  localparam int FIELD_W = 3;
  localparam int NREG    = 1 << FIELD_W;

  localparam logic [1:0]         MODE_IND  = 2'd0;
  localparam logic [1:0]         MODE_D8   = 2'd1;
  localparam logic [1:0]         MODE_D32  = 2'd2;
  localparam logic [1:0]         MODE_REG  = 2'd3;
  localparam logic [FIELD_W-1:0] RM_SIB    = 3'd4;
  localparam logic [FIELD_W-1:0] RM_ABS    = 3'd5;
  localparam logic [FIELD_W-1:0] IDX_NONE  = 3'd4;
  localparam logic [FIELD_W-1:0] BASE_NONE = 3'd5;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_B8   = 2'd1,
    DISP_W32  = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic               is_reg;
    logic               use_sib;
    logic               has_base;
    logic [FIELD_W-1:0] base_idx;
    logic               has_index;
    logic [FIELD_W-1:0] index_idx;
    logic [1:0]         scale;
    disp_kind_e         disp_kind;
  } ea_form_t;
endpackage

// File: rtl/ea_form_decode.sv
`timescale 1ns/1ps
module ea_form_decode
  import ea_pkg::*;
(
  input  logic [1:0]         mode_i,
  input  logic [FIELD_W-1:0] rm_i,
  input  logic [7:0]         sib_i,
  output ea_form_t           form_o
);
  logic [FIELD_W-1:0] sib_base;
  logic [FIELD_W-1:0] sib_index;
  logic [1:0]         sib_scale;

  assign sib_scale = sib_i[7:6];
  assign sib_index = sib_i[5:3];
  assign sib_base  = sib_i[2:0];

  always_comb begin
    form_o           = '0;
    form_o.disp_kind = DISP_NONE;
    if (mode_i == MODE_REG) begin
      form_o.is_reg = 1'b1;
    end else begin
      case (mode_i)
        MODE_D8:  form_o.disp_kind = DISP_B8;
        MODE_D32: form_o.disp_kind = DISP_W32;
        default:  form_o.disp_kind = DISP_NONE;
      endcase
      if (rm_i == RM_SIB) begin
        form_o.use_sib   = 1'b1;
        form_o.scale     = sib_scale;
        form_o.index_idx = sib_index;
        form_o.has_index = (sib_index != IDX_NONE);
        if (mode_i == MODE_IND && sib_base == BASE_NONE) begin
          // no base: absolute 4-byte displacement replaces it
          form_o.disp_kind = DISP_W32;
        end else begin
          form_o.has_base = 1'b1;
          form_o.base_idx = sib_base;
        end
      end else if (mode_i == MODE_IND && rm_i == RM_ABS) begin
        form_o.disp_kind = DISP_W32;
      end else begin
        form_o.has_base = 1'b1;
        form_o.base_idx = rm_i;
      end
    end
  end
endmodule

// File: rtl/ea_disp_ext.sv
`timescale 1ns/1ps
module ea_disp_ext
  import ea_pkg::*;
#(
  parameter  int ADDR_W = 32,
  localparam int LEN_W  = $clog2(ADDR_W / 8) + 1
) (
  input  disp_kind_e        kind_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [ADDR_W-1:0] disp_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(ADDR_W / 8);

  always_comb begin
    case (kind_i)
      DISP_B8: begin
        disp_o = {{(ADDR_W-8){disp_i[7]}}, disp_i[7:0]};
        len_o  = LEN_W'(1);
      end
      DISP_W32: begin
        disp_o = disp_i;
        len_o  = FULL_LEN;
      end
      default: begin
        disp_o = '0;
        len_o  = '0;
      end
    endcase
  end
endmodule

// File: rtl/ea_reg_pick.sv
`timescale 1ns/1ps
module ea_reg_pick
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [NREG*ADDR_W-1:0] regs_i,
  input  logic [FIELD_W-1:0]     base_idx_i,
  input  logic [FIELD_W-1:0]     index_idx_i,
  output logic [ADDR_W-1:0]      base_o,
  output logic [ADDR_W-1:0]      index_o
);
  logic [ADDR_W-1:0] reg_arr [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign reg_arr[k] = regs_i[k*ADDR_W +: ADDR_W];
  end

  assign base_o  = reg_arr[base_idx_i];
  assign index_o = reg_arr[index_idx_i];
endmodule

// File: rtl/ea_sum.sv
`timescale 1ns/1ps
module ea_sum #(
  parameter int ADDR_W = 32
) (
  input  logic              base_en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              index_en_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [1:0]        scale_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;

  always_comb begin
    case (scale_i)
      2'd1:    index_term = {index_i[ADDR_W-2:0], 1'b0};
      2'd2:    index_term = {index_i[ADDR_W-3:0], 2'b0};
      2'd3:    index_term = {index_i[ADDR_W-4:0], 3'b0};
      default: index_term = index_i;
    endcase
    if (!index_en_i) index_term = '0;
  end

  assign base_term = base_en_i ? base_i : '0;
  assign ea_o      = base_term + index_term + disp_i;
endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
  import ea_pkg::*;
#(
  parameter  int ADDR_W = 32,
  localparam int LEN_W  = $clog2(ADDR_W / 8) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [7:0]             modrm_i,
  input  logic [7:0]             sib_i,
  input  logic [ADDR_W-1:0]      disp_i,
  input  logic [NREG*ADDR_W-1:0] regs_i,
  output logic                   valid_o,
  output logic                   is_reg_o,
  output logic [FIELD_W-1:0]     reg_idx_o,
  output logic [FIELD_W-1:0]     reg_field_o,
  output logic [ADDR_W-1:0]      ea_o,
  output logic                   sib_used_o,
  output logic [LEN_W-1:0]       disp_len_o
);
  ea_form_t          form;
  logic [ADDR_W-1:0] disp_val;
  logic [LEN_W-1:0]  disp_len;
  logic [ADDR_W-1:0] base_val;
  logic [ADDR_W-1:0] index_val;
  logic [ADDR_W-1:0] sum_val;

  ea_form_decode i_decode (
    .mode_i (modrm_i[7:6]),
    .rm_i   (modrm_i[2:0]),
    .sib_i  (sib_i),
    .form_o (form)
  );

  ea_disp_ext #(.ADDR_W(ADDR_W)) i_disp (
    .kind_i (form.disp_kind),
    .disp_i (disp_i),
    .disp_o (disp_val),
    .len_o  (disp_len)
  );

  ea_reg_pick #(.ADDR_W(ADDR_W)) i_pick (
    .regs_i      (regs_i),
    .base_idx_i  (form.base_idx),
    .index_idx_i (form.index_idx),
    .base_o      (base_val),
    .index_o     (index_val)
  );

  ea_sum #(.ADDR_W(ADDR_W)) i_sum (
    .base_en_i  (form.has_base),
    .base_i     (base_val),
    .index_en_i (form.has_index),
    .index_i    (index_val),
    .scale_i    (form.scale),
    .disp_i     (disp_val),
    .ea_o       (sum_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_reg_o    <= 1'b0;
      reg_idx_o   <= '0;
      reg_field_o <= '0;
      ea_o        <= '0;
      sib_used_o  <= 1'b0;
      disp_len_o  <= '0;
    end else if (valid_i) begin
      is_reg_o    <= form.is_reg;
      reg_idx_o   <= form.is_reg ? modrm_i[2:0] : '0;
      reg_field_o <= modrm_i[5:3];
      ea_o        <= form.is_reg ? '0 : sum_val;
      sib_used_o  <= form.use_sib;
      disp_len_o  <= disp_len;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
`timescale 1ns/1ps
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter  int ADDR_W = 32,
  localparam int LEN_W  = $clog2(ADDR_W / 8) + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [7:0]         modrm_i,
  input logic [ADDR_W-1:0]  disp_i,
  input logic               valid_o,
  input logic               is_reg_o,
  input logic [FIELD_W-1:0] reg_idx_o,
  input logic [ADDR_W-1:0]  ea_o,
  input logic               sib_used_o,
  input logic [LEN_W-1:0]   disp_len_o
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(ADDR_W / 8);

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(ea_o) && $stable(is_reg_o) && $stable(reg_idx_o)
                  && $stable(disp_len_o)));

  a_r1_reg_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == MODE_REG) |=>
      (is_reg_o && reg_idx_o == $past(modrm_i[2:0]) && ea_o == '0
       && !sib_used_o && disp_len_o == '0));

  a_r3_short_disp_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == MODE_D8) |=> (!is_reg_o && disp_len_o == LEN_W'(1)));

  a_r4_full_disp_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == MODE_D32) |=> (!is_reg_o && disp_len_o == FULL_LEN));

  a_r5_absolute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == MODE_IND && modrm_i[2:0] == RM_ABS) |=>
      (ea_o == $past(disp_i) && !sib_used_o && disp_len_o == FULL_LEN));

  a_r6_sib_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] != MODE_REG) |=> (sib_used_o == ($past(modrm_i[2:0]) == RM_SIB)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r11_reset_zero: assert (!valid_o && !is_reg_o && ea_o == '0 && disp_len_o == '0
                                && !sib_used_o);
    end
  end
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) i_ea_gen_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .modrm_i    (modrm_i),
  .disp_i     (disp_i),
  .valid_o    (valid_o),
  .is_reg_o   (is_reg_o),
  .reg_idx_o  (reg_idx_o),
  .ea_o       (ea_o),
  .sib_used_o (sib_used_o),
  .disp_len_o (disp_len_o)
);

// File: tb/test_ea_gen.sv
`timescale 1ns/1ps
module test_ea_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         valid = 1'b0;
  logic [7:0]   modrm = '0;
  logic [7:0]   sib = '0;
  logic [31:0]  disp = '0;
  logic [255:0] regs = '0;
  logic         valid_o;
  logic         is_reg;
  logic [2:0]   reg_idx;
  logic [2:0]   reg_field;
  logic [31:0]  ea;
  logic         sib_used;
  logic [2:0]   disp_len;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ea_gen i_ea_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .valid_i     (valid),
    .modrm_i     (modrm),
    .sib_i       (sib),
    .disp_i      (disp),
    .regs_i      (regs),
    .valid_o     (valid_o),
    .is_reg_o    (is_reg),
    .reg_idx_o   (reg_idx),
    .reg_field_o (reg_field),
    .ea_o        (ea),
    .sib_used_o  (sib_used),
    .disp_len_o  (disp_len)
  );

  function automatic logic [31:0] regv(input int k);
    return 32'h0100_0000 * (k + 1) + 32'h10 * k + 32'h3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_regs();
    for (int k = 0; k < 8; k++) regs[k*32 +: 32] = regv(k);
  endtask

  // one request; returns with results registered, sampled at falling edge
  task automatic issue(input logic [1:0] md, input logic [2:0] rf, input logic [2:0] rm,
                       input logic [7:0] sb, input logic [31:0] dp);
    @(negedge clk);
    modrm = {md, rf, rm};
    sib   = sb;
    disp  = dp;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 valid", {31'b0, valid_o}, 32'h0);
    chk("R11 ea", ea, 32'h0);
    chk("R11 is_reg", {31'b0, is_reg}, 32'h0);
    chk("R11 len", {29'b0, disp_len}, 32'h0);
  endtask

  task automatic t_reg_form();
    issue(2'd3, 3'd2, 3'd6, 8'h24, 32'hFFFF_FFFF);
    chk("R1 valid_o", {31'b0, valid_o}, 32'h1);
    chk("R1 is_reg", {31'b0, is_reg}, 32'h1);
    chk("R1 idx", {29'b0, reg_idx}, 32'd6);
    chk("R1 reg field", {29'b0, reg_field}, 32'd2);
    chk("R1 ea", ea, 32'h0);
    chk("R1 sib", {31'b0, sib_used}, 32'h0);
    chk("R1 len", {29'b0, disp_len}, 32'h0);
  endtask

  task automatic t_indirect();
    issue(2'd0, 3'd0, 3'd3, 8'hFF, 32'h5555_5555);
    chk("R2 ea", ea, regv(3));
    chk("R2 is_reg", {31'b0, is_reg}, 32'h0);
    chk("R2 len", {29'b0, disp_len}, 32'h0);
  endtask

  task automatic t_disp8();
    issue(2'd1, 3'd0, 3'd1, 8'h00, 32'hABCD_EFF0);
    chk("R3 neg ea", ea, regv(1) - 32'd16);
    chk("R3 len", {29'b0, disp_len}, 32'd1);
    issue(2'd1, 3'd0, 3'd7, 8'h00, 32'h8000_007F);
    chk("R3 pos ea", ea, regv(7) + 32'h7F);
  endtask

  task automatic t_disp32();
    issue(2'd2, 3'd5, 3'd7, 8'h00, 32'h1234_5678);
    chk("R4 ea", ea, regv(7) + 32'h1234_5678);
    chk("R4 len", {29'b0, disp_len}, 32'd4);
  endtask

  task automatic t_absolute();
    issue(2'd0, 3'd0, 3'd5, 8'h00, 32'hDEAD_BEEF);
    chk("R5 ea", ea, 32'hDEAD_BEEF);
    chk("R5 len", {29'b0, disp_len}, 32'd4);
    chk("R5 sib", {31'b0, sib_used}, 32'h0);
  endtask

  task automatic t_sib_scale();
    for (int s = 0; s < 4; s++) begin
      issue(2'd1, 3'd0, 3'd4, {s[1:0], 3'd2, 3'd0}, 32'h0000_0004);
      chk("R6 scaled ea", ea, regv(0) + (regv(2) << s) + 32'd4);
      chk("R6 sib used", {31'b0, sib_used}, 32'h1);
    end
  endtask

  task automatic t_no_index();
    issue(2'd0, 3'd0, 3'd4, {2'd3, 3'd4, 3'd4}, 32'h0);
    chk("R7 ea", ea, regv(4));
    chk("R7 len", {29'b0, disp_len}, 32'h0);
  endtask

  task automatic t_no_base();
    issue(2'd0, 3'd0, 3'd4, {2'd3, 3'd1, 3'd5}, 32'h0000_1000);
    chk("R8 nobase ea", ea, (regv(1) << 3) + 32'h1000);
    chk("R8 nobase len", {29'b0, disp_len}, 32'd4);
    issue(2'd1, 3'd0, 3'd4, {2'd3, 3'd1, 3'd5}, 32'h0000_0080);
    chk("R8 base5 ea", ea, regv(5) + (regv(1) << 3) - 32'd128);
    chk("R8 base5 len", {29'b0, disp_len}, 32'd1);
  endtask

  task automatic t_wrap();
    regs[31:0] = 32'hFFFF_FFF0;
    issue(2'd2, 3'd0, 3'd0, 8'h00, 32'h0000_0020);
    chk("R9 wrap ea", ea, 32'h0000_0010);
    load_regs();
  endtask

  task automatic t_hold();
    issue(2'd2, 3'd0, 3'd2, 8'h00, 32'h0000_0100);
    @(negedge clk);
    modrm = {2'd3, 3'd1, 3'd1};
    disp  = 32'h7777_7777;
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle valid", {31'b0, valid_o}, 32'h0);
    chk("R10 hold ea", ea, regv(2) + 32'h100);
    chk("R10 hold is_reg", {31'b0, is_reg}, 32'h0);
    chk("R10 hold len", {29'b0, disp_len}, 32'd4);
  endtask

  initial begin
    load_regs();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reg_form();
    t_indirect();
    t_disp8();
    t_disp32();
    t_absolute();
    t_sib_scale();
    t_no_index();
    t_no_base();
    t_wrap();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule